// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Manual Set

This block holds the time of day as three packed BCD bytes: seconds, minutes and hours, with hours in 24-hour form. Everything runs on one system clock. A one-cycle tick input, produced elsewhere at 1 Hz, advances the time by one second whenever the run enable is high. The block only keeps time. Tick generation and display driving are done outside it.

Two set switches let an operator change the time by hand. While the minute switch is on, minutes step once on every tick, whatever the seconds are doing. While the hour switch is on, hours step once on every tick. Seconds keep counting during either adjustment. A minute wrap caused by the minute switch does not carry into hours, so the hour setting is not disturbed.

A flag output goes high whenever minutes and seconds both read zero, which marks the top of each hour. Each counter also recovers by itself: any illegal BCD code returns that counter to 00 on its next step.

Top module: `bcd_time_core`

## Requirements
- R1: A clock edge with `rst_n` low sets seconds, minutes and hours to 8'h00 on the next cycle. This clear overrides every other input.
- R2: While `run_en` is low, all three outputs hold their values, even when `tick`, `adj_min` and `adj_hour` are active.
- R3: Each tick taken with `run_en` high advances seconds by one, in packed BCD (tens in bits 7:4, units in bits 3:0). The count goes from 8'h59 to 8'h00. Cycles without a tick leave the time unchanged.
- R4: With no adjust switch on, minutes advance by one on a tick taken while seconds read 8'h59, and wrap from 8'h59 to 8'h00.
- R5: Hours advance by one on a tick taken while minutes and seconds both read 8'h59 and `adj_min` is low. 23:59:59 rolls over to 00:00:00.
- R6: While `adj_min` is high, every running tick steps minutes by one, whatever the seconds value. Seconds still advance on the same tick.
- R7: A minute wrap from 8'h59 to 8'h00 that happens while `adj_min` is high leaves hours unchanged, unless `adj_hour` is also high.
- R8: While `adj_hour` is high, every running tick steps hours by one, and hours go from 8'h23 to 8'h00.
- R9: `top_of_hour` is 1 exactly when minutes and seconds both read 8'h00, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low clear of all counters |
| run_en | input | 1 | High lets the clock run; low freezes all counters |
| tick | input | 1 | One-cycle pulse, one per second |
| adj_min | input | 1 | Minute set switch |
| adj_hour | input | 1 | Hour set switch |
| sec_bcd | output | 8 | Seconds, packed BCD 00..59 |
| min_bcd | output | 8 | Minutes, packed BCD 00..59 |
| hour_bcd | output | 8 | Hours, packed BCD 00..23 |
| top_of_hour | output | 1 | High when minutes and seconds are both zero |

## Verification
The assertions take two things for granted about the inputs. First, `tick` is a single-cycle pulse sampled on the system clock. Second, the switch inputs change only at clock boundaries, so each tick sees one stable switch setting. The bench meets both by driving every input on the falling edge and raising `tick` for exactly one cycle. It also holds `rst_n` low for several edges, so every register is defined before any property is armed. Illegal BCD codes cannot be reached through the ports, so the stimulus only walks legal times. That includes the 59 and 23 wrap boundaries, reached through the set switches.

// File: rtl/bcd_time_pkg.sv
`timescale 1ns/1ps
// bcd_time_pkg
// Purpose : shared types and helpers for the BCD time-of-day counter.
// Assumes : a BCD digit is four bits wide and a pair is packed tens:units.
package bcd_time_pkg;

    localparam int DIGIT_W = 4;
    localparam int PAIR_W  = 2 * DIGIT_W;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    typedef struct packed {
        bcd_digit_t tens;
        bcd_digit_t units;
    } bcd_pair_t;

    localparam bcd_pair_t PAIR_ZERO = '{tens: '0, units: '0};

    // Returns 1 when the pair equals the given decimal digits.
    function automatic logic pair_equals(bcd_pair_t p, int t, int u);
        return (p.tens == DIGIT_W'(t)) && (p.units == DIGIT_W'(u));
    endfunction

endpackage

// File: rtl/bcd_step_ctrl.sv
`timescale 1ns/1ps
// bcd_step_ctrl
// Purpose : decides on each clock which counters step, from the tick,
//           the run enable, the set switches and the lower-digit carries.
// Assumes : tick is a one-cycle pulse; sec_last/min_last come from the
//           current counter state (no pipelining between them).
module bcd_step_ctrl (
    input  logic run_en,
    input  logic tick,
    input  logic adj_min,
    input  logic adj_hour,
    input  logic sec_last,
    input  logic min_last,
    output logic sec_step,
    output logic min_step,
    output logic hour_step
);

    logic advance;

    // Purpose: one running tick gates every step.
    always_comb begin
        advance   = run_en && tick;
        sec_step  = advance;
        min_step  = advance && (adj_min || sec_last);
        // The natural hour carry is masked while minutes are being set.
        hour_step = advance && (adj_hour || (!adj_min && sec_last && min_last));
    end

endmodule

// File: rtl/bcd_pair_counter.sv
`timescale 1ns/1ps
// bcd_pair_counter
// Purpose : two-digit BCD counter for 00..(TENS_LAST)(UNITS_LAST), e.g. 00..59.
//           Steps once per cycle where step is high and wraps to 00 after
//           the last value. An out-of-range digit returns the pair to 00.
// Assumes : synchronous active-low clear; step is already qualified.
module bcd_pair_counter
    import bcd_time_pkg::*;
#(
    parameter int TENS_LAST  = 5,
    parameter int UNITS_LAST = 9
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    output bcd_pair_t q,
    output logic      at_last
);

    localparam bcd_digit_t TENS_MAX  = DIGIT_W'(TENS_LAST);
    localparam bcd_digit_t UNITS_MAX = DIGIT_W'(UNITS_LAST);

    bcd_pair_t q_nxt;
    logic      illegal;

    // Purpose: flag the last legal value and any illegal code.
    always_comb begin
        at_last = (q.tens == TENS_MAX) && (q.units == UNITS_MAX);
        illegal = (q.tens > TENS_MAX) || (q.units > UNITS_MAX);
    end

    // Purpose: next value of the pair, digit by digit.
    always_comb begin
        q_nxt = q;
        if (illegal || at_last) begin
            q_nxt = PAIR_ZERO;
        end else if (q.units == UNITS_MAX) begin
            q_nxt.tens  = q.tens + 1'b1;
            q_nxt.units = '0;
        end else begin
            q_nxt.units = q.units + 1'b1;
        end
    end

    // Purpose: state register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= PAIR_ZERO;
        end else if (step) begin
            q <= q_nxt;
        end
    end

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(q)); // R3
    AST_PAIR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_last) |=> (q == PAIR_ZERO)); // R4
    AST_PAIR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (q != $past(q))); // R6

endmodule

// File: rtl/bcd_hour_counter.sv
`timescale 1ns/1ps
// bcd_hour_counter
// Purpose : BCD hour counter for 00..(LAST_TENS)(LAST_UNITS), default 00..23.
//           Any value past the last hour, or a units digit above 9,
//           returns to 00 on the next step.
// Assumes : synchronous active-low clear; step is already qualified.
module bcd_hour_counter
    import bcd_time_pkg::*;
#(
    parameter int LAST_TENS  = 2,
    parameter int LAST_UNITS = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    output bcd_pair_t q
);

    localparam bcd_digit_t TENS_MAX  = DIGIT_W'(LAST_TENS);
    localparam bcd_digit_t UNITS_END = DIGIT_W'(LAST_UNITS);
    localparam bcd_digit_t DEC_NINE  = DIGIT_W'(9);

    bcd_pair_t q_nxt;
    logic      wrap_now;

    // Purpose: detect the last hour or any out-of-range hour code.
    always_comb begin
        wrap_now = (q.tens > TENS_MAX) || (q.units > DEC_NINE) ||
                   ((q.tens == TENS_MAX) && (q.units >= UNITS_END));
    end

    // Purpose: next hour value.
    always_comb begin
        q_nxt = q;
        if (wrap_now) begin
            q_nxt = PAIR_ZERO;
        end else if (q.units == DEC_NINE) begin
            q_nxt.tens  = q.tens + 1'b1;
            q_nxt.units = '0;
        end else begin
            q_nxt.units = q.units + 1'b1;
        end
    end

    // Purpose: hour register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= PAIR_ZERO;
        end else if (step) begin
            q <= q_nxt;
        end
    end

    AST_HOUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(q)); // R2
    AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && pair_equals(q, LAST_TENS, LAST_UNITS)) |=> (q == PAIR_ZERO)); // R8

endmodule

// File: rtl/bcd_time_core.sv
`timescale 1ns/1ps
// bcd_time_core
// Purpose : time-of-day counter in packed BCD (seconds, minutes, 24-hour
//           hours) advanced by a 1 Hz tick, with minute and hour set switches
//           and a top-of-hour flag.
// Assumes : tick is a one-cycle pulse in the clk domain; switches are
//           synchronous to clk; rst_n is a synchronous active-low clear.
module bcd_time_core
    import bcd_time_pkg::*;
#(
    parameter int MS_TENS_LAST  = 5,
    parameter int MS_UNITS_LAST = 9,
    parameter int HR_LAST_TENS  = 2,
    parameter int HR_LAST_UNITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              tick,
    input  logic              adj_min,
    input  logic              adj_hour,
    output logic [PAIR_W-1:0] sec_bcd,
    output logic [PAIR_W-1:0] min_bcd,
    output logic [PAIR_W-1:0] hour_bcd,
    output logic              top_of_hour
);

    localparam int NUM_PAIRS = 2;   // index 0 = seconds, 1 = minutes

    bcd_pair_t        pair_q    [NUM_PAIRS];
    logic             pair_step [NUM_PAIRS];
    logic             pair_last [NUM_PAIRS];
    bcd_pair_t        hour_q;
    logic             hour_step;

    bcd_step_ctrl u_ctrl (
        .run_en    (run_en),
        .tick      (tick),
        .adj_min   (adj_min),
        .adj_hour  (adj_hour),
        .sec_last  (pair_last[0]),
        .min_last  (pair_last[1]),
        .sec_step  (pair_step[0]),
        .min_step  (pair_step[1]),
        .hour_step (hour_step)
    );

    // Seconds and minutes share one counter shape.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        bcd_pair_counter #(
            .TENS_LAST  (MS_TENS_LAST),
            .UNITS_LAST (MS_UNITS_LAST)
        ) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (pair_step[g]),
            .q       (pair_q[g]),
            .at_last (pair_last[g])
        );
    end

    bcd_hour_counter #(
        .LAST_TENS  (HR_LAST_TENS),
        .LAST_UNITS (HR_LAST_UNITS)
    ) u_hour (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (hour_step),
        .q     (hour_q)
    );

    // Purpose: drive the outputs and the top-of-hour flag.
    always_comb begin
        sec_bcd     = pair_q[0];
        min_bcd     = pair_q[1];
        hour_bcd    = hour_q;
        top_of_hour = (pair_q[1] == PAIR_ZERO) && (pair_q[0] == PAIR_ZERO);
    end

    AST_FREEZE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable({sec_bcd, min_bcd, hour_bcd})); // R2
    AST_ADJ_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && adj_min && !adj_hour) |=> $stable(hour_bcd)); // R7
    AST_MIN_ADJ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && adj_min) |=> (min_bcd != $past(min_bcd))); // R6
    AST_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && !adj_min && !adj_hour && hour_bcd == 8'h23 &&
         min_bcd == 8'h59 && sec_bcd == 8'h59)
        |=> (hour_bcd == 8'h00 && min_bcd == 8'h00 && sec_bcd == 8'h00)); // R5

endmodule

// File: tb/bcd_time_core_tb.sv
`timescale 1ns/1ps
// Directed bench for bcd_time_core: a decimal reference model tracks the
// expected time; each scenario task drives stimulus and checks results.
module bcd_time_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       tick = 1'b0;
    logic       adj_min = 1'b0;
    logic       adj_hour = 1'b0;
    logic [7:0] sec_bcd, min_bcd, hour_bcd;
    logic       top_of_hour;

    int n_checks = 0;
    int n_fail   = 0;
    int m_s = 0, m_m = 0, m_h = 0;   // reference model, decimal

    always #2 clk = ~clk;   // 250 MHz

    bcd_time_core u_dut (
        .clk (clk), .rst_n (rst_n), .run_en (run_en), .tick (tick),
        .adj_min (adj_min), .adj_hour (adj_hour),
        .sec_bcd (sec_bcd), .min_bcd (min_bcd), .hour_bcd (hour_bcd),
        .top_of_hour (top_of_hour)
    );

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check8(req, "sec",  sec_bcd,  to_bcd(m_s));
        check8(req, "min",  min_bcd,  to_bcd(m_m));
        check8(req, "hour", hour_bcd, to_bcd(m_h));
        check8(req, "top_of_hour", {7'd0, top_of_hour},
               {7'd0, (m_m == 0 && m_s == 0)});
    endtask

    // One clock with the given inputs; outputs are read at the next falling edge.
    task automatic cycle(logic run, logic tk, logic am, logic ah);
        run_en = run; tick = tk; adj_min = am; adj_hour = ah;
        @(negedge clk);
        if (run && tk) begin
            logic mstep, hstep;
            mstep = am || (m_s == 59);
            hstep = ah || (!am && m_m == 59 && m_s == 59);
            m_s = (m_s + 1) % 60;
            if (mstep) m_m = (m_m + 1) % 60;
            if (hstep) m_h = (m_h + 1) % 24;
        end
        tick = 1'b0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_s = 0; m_m = 0; m_h = 0;
        rst_n = 1'b1;
        run_en = 1'b1;
    endtask

    task automatic t_reset();
        apply_reset();
        check_all("R1");
        check8("R9", "top flag at 00:00", {7'd0, top_of_hour}, 8'd1);
    endtask

    task automatic t_seconds();
        for (int i = 0; i < 12; i++) begin
            cycle(1, 1, 0, 0);
            check_all("R3");
            cycle(1, 0, 0, 0);   // idle cycle must not move the time
            check_all("R3");
        end
        check8("R9", "top flag off", {7'd0, top_of_hour}, 8'd0);
    endtask

    task automatic t_minute_carry();
        while (m_s != 59) cycle(1, 1, 0, 0);
        check8("R3", "sec at 59", sec_bcd, 8'h59);
        cycle(1, 1, 0, 0);
        check8("R3", "sec wrap", sec_bcd, 8'h00);
        check8("R4", "min carry", min_bcd, 8'h01);
        check_all("R4");
    endtask

    task automatic t_freeze();
        logic [7:0] s0, m0, h0;
        s0 = sec_bcd; m0 = min_bcd; h0 = hour_bcd;
        for (int i = 0; i < 6; i++) cycle(0, 1, 1, 1);
        check8("R2", "sec frozen",  sec_bcd,  s0);
        check8("R2", "min frozen",  min_bcd,  m0);
        check8("R2", "hour frozen", hour_bcd, h0);
    endtask

    task automatic t_min_adjust();
        for (int i = 0; i < 70; i++) begin
            cycle(1, 1, 1, 0);
            check_all("R6");
        end
    endtask

    task automatic t_min_adj_wrap();
        int h0;
        apply_reset();
        while (m_m != 59) cycle(1, 1, 1, 0);
        h0 = m_h;
        cycle(1, 1, 1, 0);
        check8("R7", "min wrap", min_bcd, 8'h00);
        check8("R7", "hour kept", hour_bcd, to_bcd(h0));
        // Seconds reach 59 while minutes sit at 59 under adjust: still no carry.
        while (m_m != 59 || m_s != 59) cycle(1, 1, 1, 0);
        cycle(1, 1, 1, 0);
        check8("R7", "hour kept at 59:59", hour_bcd, to_bcd(h0));
        check_all("R7");
    endtask

    task automatic t_hour_adjust();
        apply_reset();
        for (int i = 0; i < 23; i++) begin
            cycle(1, 1, 0, 1);
            check_all("R8");
        end
        check8("R8", "hour at 23", hour_bcd, 8'h23);
        cycle(1, 1, 0, 1);
        check8("R8", "hour wrap", hour_bcd, 8'h00);
    endtask

    task automatic t_rollover();
        apply_reset();
        while (m_h != 23) cycle(1, 1, 0, 1);
        while (m_m != 59) cycle(1, 1, 1, 0);
        while (m_s != 59) cycle(1, 1, 0, 0);
        check_all("R5");
        cycle(1, 1, 0, 0);
        check8("R5", "rollover sec",  sec_bcd,  8'h00);
        check8("R5", "rollover min",  min_bcd,  8'h00);
        check8("R5", "rollover hour", hour_bcd, 8'h00);
        check8("R9", "top flag on", {7'd0, top_of_hour}, 8'd1);
    endtask

    task automatic t_hour_carry();
        apply_reset();
        while (m_h != 5) cycle(1, 1, 0, 1);
        while (m_m != 59) cycle(1, 1, 1, 0);
        while (m_s != 59) cycle(1, 1, 0, 0);
        cycle(1, 1, 0, 0);
        check8("R5", "hour carry", hour_bcd, 8'h06);
        check_all("R5");
    endtask

    task automatic t_clear_midrun();
        for (int i = 0; i < 7; i++) cycle(1, 1, 0, 0);
        rst_n = 1'b0; tick = 1'b1; adj_min = 1'b1; adj_hour = 1'b1;
        @(negedge clk);
        tick = 1'b0; adj_min = 1'b0; adj_hour = 1'b0;
        check8("R1", "clear sec",  sec_bcd,  8'h00);
        check8("R1", "clear min",  min_bcd,  8'h00);
        check8("R1", "clear hour", hour_bcd, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        m_s = 0; m_m = 0; m_h = 0;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_seconds();
        t_minute_carry();
        t_freeze();
        t_min_adjust();
        t_min_adj_wrap();
        t_hour_adjust();
        t_rollover();
        t_hour_carry();
        t_clear_midrun();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule